// File: doc/BRIEF.md
# Standby Mode Control Register

This block holds the 8-bit control register that decides what the processor does when it executes its sleep instruction, and it tracks the power state that follows. Software reads and writes the register over a simple bus with a write enable, write data and combinational read data. One control bit picks light sleep or deep standby. A second bit chooses whether the I/O ports float during standby. A third bit decides whether the external interrupt lines may end standby.

The block takes a one-cycle sleep-request pulse, the watchdog's enable bit, the external interrupt request lines and a non-maskable wake input. It drives registered sleep-active and standby-active flags and a port-float flag. While the watchdog runs, the two bits that would lead to standby or to floating ports cannot be set. Register writes are accepted only while the processor is running.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the register reads 8'h1F, and sleep_act, stby_act and port_hiz are all 0.
- R2: A sleep_req pulse in the running state sets sleep_act on the next cycle when bit 7 is 0, and sets stby_act on the next cycle when bit 7 is 1. The value of bit 7 held at the time of the pulse decides.
- R3: Bit 7 (standby select) resets to 0. A write of 1 to it is dropped while wdog_en is 1, and the bit keeps its old value. A write of 0 is always taken.
- R4: Bit 6 (port float select) resets to 0. A write of 1 to it is dropped while wdog_en is 1. Otherwise it takes the written value.
- R5: Bit 5 always reads 0 and bits 4 to 1 always read 1. Writes to these bits change nothing.
- R6: Bit 0 (interrupt hold) resets to 1 and takes the written value. In standby, any irq line ends standby on the next cycle only while bit 0 is 0. While bit 0 is 1, irq lines leave the block in standby.
- R7: In standby, nmi_wake always returns the block to the running state on the next cycle. In sleep, any irq line or nmi_wake returns it to the running state on the next cycle.
- R8: port_hiz is 1 exactly while stby_act is 1 and bit 6 is 1. It falls on the same edge on which stby_act falls.
- R9: Writes are ignored while sleep_act or stby_act is 1. A sleep_req that arrives while sleep_act or stby_act is 1 is ignored.
- R10: sleep_act and stby_act are never 1 together. Both are 0 in the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| wdog_en | input | 1 | Watchdog running flag |
| sleep_req | input | 1 | One-cycle sleep instruction pulse |
| irq | input | NUM_IRQ (4) | External interrupt requests |
| nmi_wake | input | 1 | Non-maskable wake input |
| sleep_act | output | 1 | Sleep state active |
| stby_act | output | 1 | Standby state active |
| port_hiz | output | 1 | Ports float during standby |

## Verification
On every cycle, the assertions check several properties. The two state flags are never set together. The port-float flag never shows outside standby. A dropped write under an enabled watchdog leaves bits 7 and 6 clear. Every sleep request in the running state lands in the state that bit 7 selects. A non-maskable wake always ends standby, and the register holds still outside the running state.

Some behaviours only the bench scenarios can show: the exact reset read value, the reserved bit pattern after arbitrary writes, and interrupt hold blocking a wake in standby while a clear hold permits it. The bench compares all of these against a cycle model over long random runs.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_MODE  = 7;
  localparam int BIT_FLOAT = 6;
  localparam int BIT_HOLD  = 0;
  localparam logic [4:0] RSVD_PATTERN = 5'b01111; // bits 5..1

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_STBY  = 2'd2
  } pm_state_e;

  typedef struct packed {
    logic mode_stby;
    logic port_float;
    logic irq_hold;
  } pm_cfg_t;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pmc_cfg_reg.sv
module pmc_cfg_reg
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             wdog_en,
  output pm_cfg_t          cfg,
  output logic [REG_W-1:0] rdata
);
  pm_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      if (!(wdata[BIT_MODE] && wdog_en))  cfg_d.mode_stby  = wdata[BIT_MODE];
      if (!(wdata[BIT_FLOAT] && wdog_en)) cfg_d.port_float = wdata[BIT_FLOAT];
      cfg_d.irq_hold = wdata[BIT_HOLD];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.mode_stby  <= 1'b0;
      cfg_q.port_float <= 1'b0;
      cfg_q.irq_hold   <= 1'b1;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg   = cfg_q;
  assign rdata = {cfg_q.mode_stby, cfg_q.port_float, RSVD_PATTERN, cfg_q.irq_hold};

  // R3: blocked set of standby select keeps it clear
  p_mode_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdog_en && !cfg_q.mode_stby) |=> !cfg_q.mode_stby);
  // R4: blocked set of port float keeps it clear
  p_float_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdog_en && !cfg_q.port_float) |=> !cfg_q.port_float);
endmodule

// File: rtl/pmc_wake.sv
module pmc_wake #(
  parameter int NUM_IRQ = 4
) (
  input  logic [NUM_IRQ-1:0] irq,
  input  logic               nmi_wake,
  input  logic               irq_hold,
  output logic               wake_sleep,
  output logic               wake_stby
);
  logic any_irq;
  assign any_irq    = |irq;
  assign wake_sleep = any_irq | nmi_wake;
  assign wake_stby  = nmi_wake | (any_irq & ~irq_hold);
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      mode_stby,
  input  logic      wake_sleep,
  input  logic      wake_stby,
  output pm_state_e state,
  output logic      sleep_act,
  output logic      stby_act
);
  pm_state_e state_q, state_d;
  logic sleep_q, stby_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN:   if (sleep_req) state_d = mode_stby ? PM_STBY : PM_SLEEP;
      PM_SLEEP: if (wake_sleep) state_d = PM_RUN;
      PM_STBY:  if (wake_stby)  state_d = PM_RUN;
      default:  state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      sleep_q <= 1'b0;
      stby_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sleep_q <= (state_d == PM_SLEEP);
      stby_q  <= (state_d == PM_STBY);
    end
  end

  assign state     = state_q;
  assign sleep_act = sleep_q;
  assign stby_act  = stby_q;

  // R10: flags exclusive
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_q && stby_q));
  // R2: entry follows standby select
  p_enter_stby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_q && !stby_q && sleep_req && mode_stby) |=> stby_q);
  p_enter_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_q && !stby_q && sleep_req && !mode_stby) |=> sleep_q);
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pmc_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               wdog_en,
  input  logic               sleep_req,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic               nmi_wake,
  output logic               sleep_act,
  output logic               stby_act,
  output logic               port_hiz
);
  logic      rst_i_n;
  pm_cfg_t   cfg;
  pm_state_e state;
  logic      wr_ok, wake_sleep, wake_stby;

  pmc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  assign wr_ok = reg_we && (state == PM_RUN);

  pmc_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_ok), .wdata(reg_wdata),
    .wdog_en(wdog_en), .cfg(cfg), .rdata(reg_rdata)
  );

  pmc_wake #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq(irq), .nmi_wake(nmi_wake), .irq_hold(cfg.irq_hold),
    .wake_sleep(wake_sleep), .wake_stby(wake_stby)
  );

  pmc_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n), .sleep_req(sleep_req), .mode_stby(cfg.mode_stby),
    .wake_sleep(wake_sleep), .wake_stby(wake_stby), .state(state),
    .sleep_act(sleep_act), .stby_act(stby_act)
  );

  assign port_hiz = stby_act & cfg.port_float;

  // R8: float only in standby
  p_float_in_stby_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    port_hiz |-> stby_act);
  // R7: nmi always leaves standby
  p_nmi_exit_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (stby_act && nmi_wake) |=> (!stby_act && !sleep_act));
  // R9: register frozen outside running state
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sleep_act || stby_act) |=> $stable(reg_rdata));
endmodule

// File: tb/sim_pwr_mode_ctl.sv
module sim_pwr_mode_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic wdog_en = 1'b0, sleep_req = 1'b0, nmi_wake = 1'b0;
  logic [3:0] irq = 4'h0;
  logic sleep_act, stby_act, port_hiz;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  bit m_mode, m_float, m_hold;
  int m_st; // 0 run, 1 sleep, 2 standby

  always #5 clk = ~clk;

  pwr_mode_ctl #(.NUM_IRQ(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wdog_en(wdog_en), .sleep_req(sleep_req),
    .irq(irq), .nmi_wake(nmi_wake), .sleep_act(sleep_act),
    .stby_act(stby_act), .port_hiz(port_hiz)
  );

  function automatic logic [7:0] exp_rdata();
    return {m_mode, m_float, 1'b0, 4'hF, m_hold};
  endfunction

  function automatic int next_state(int st, bit sreq, logic [3:0] ir, bit nmi);
    if (st == 0) return sreq ? (m_mode ? 2 : 1) : 0;
    if (st == 1) return (|ir || nmi) ? 0 : 1;
    return (nmi || (|ir && !m_hold)) ? 0 : 2;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R3", {7'd0, reg_rdata[7]}, {7'd0, m_mode});
    chk("R4", {7'd0, reg_rdata[6]}, {7'd0, m_float});
    chk("R5", {3'd0, reg_rdata[5:1]}, 8'h0F);
    chk("R6", {7'd0, reg_rdata[0]}, {7'd0, m_hold});
    chk("R10", {6'd0, sleep_act, stby_act}, {6'd0, m_st == 1, m_st == 2});
    chk("R8", {7'd0, port_hiz}, {7'd0, (m_st == 2) && m_float});
  endtask

  task automatic step(bit we, logic [7:0] wd, bit wd_en, bit sreq, logic [3:0] ir, bit nmi);
    int ns;
    @(negedge clk);
    reg_we = we; reg_wdata = wd; wdog_en = wd_en; sleep_req = sreq; irq = ir; nmi_wake = nmi;
    ns = next_state(m_st, sreq, ir, nmi);
    if (m_st == 0 && we) begin
      if (!(wd[7] && wd_en)) m_mode = wd[7];
      if (!(wd[6] && wd_en)) m_float = wd[6];
      m_hold = wd[0];
    end
    m_st = ns;
    @(posedge clk); #1;
    reg_we = 0; sleep_req = 0; irq = 0; nmi_wake = 0;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_mode = 0; m_float = 0; m_hold = 1; m_st = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    chk("R1", reg_rdata, 8'h1F);
    chk("R1", {5'd0, sleep_act, stby_act, port_hiz}, 8'h00);

    // R3/R4: set blocked under watchdog, then clear accepted
    step(1, 8'hC1, 1, 0, 0, 0);
    chk("R3", reg_rdata, 8'h1F);
    step(1, 8'hC0, 0, 0, 0, 0);
    chk("R4", reg_rdata, 8'hDE);
    step(1, 8'h3E, 1, 0, 0, 0);   // write 0 to bit7 with watchdog on: taken
    chk("R3", reg_rdata, 8'h1E);
    // R2 sleep path; R7 irq wake from sleep
    step(0, 0, 0, 1, 0, 0);
    chk("R2", {6'd0, sleep_act, stby_act}, 8'h02);
    // R9: write and sleep_req ignored in sleep
    step(1, 8'hFF, 0, 1, 0, 0);
    chk("R9", reg_rdata, 8'h1E);
    chk("R9", {6'd0, sleep_act, stby_act}, 8'h02);
    step(0, 0, 0, 0, 4'h8, 0);
    chk("R7", {6'd0, sleep_act, stby_act}, 8'h00);
    // enter standby with float and hold set
    step(1, 8'hC1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    chk("R2", {6'd0, sleep_act, stby_act}, 8'h01);
    chk("R8", {7'd0, port_hiz}, 8'h01);
    step(0, 0, 0, 0, 4'h1, 0);   // held: stays in standby
    chk("R6", {7'd0, stby_act}, 8'h01);
    step(0, 0, 0, 0, 0, 1);      // nmi wakes
    chk("R7", {6'd0, stby_act, port_hiz}, 8'h00);
    // hold cleared: irq wakes standby
    step(1, 8'h80, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 4'h4, 0);
    chk("R6", {7'd0, stby_act}, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      bit we, wden, sreq, nmi;
      logic [3:0] ir;
      we   = ($urandom % 4) == 0;
      wden = ($urandom % 3) == 0;
      sreq = ($urandom % 8) == 0;
      nmi  = ($urandom % 40) == 0;
      ir   = (($urandom % 10) == 0) ? 4'($urandom) : 4'h0;
      step(we, 8'($urandom), wden, sreq, ir, nmi);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule